// File: doc/BRIEF.md
# Three-Phase Hall Commutation Logic

This block turns the three digital Hall-sensor levels of a brushless motor into six gate-drive enables: one high-side and one low-side enable for each of the phases U, V and W. It selects the rotation direction, can hold the motor in a short brake, can stop the drive completely, and chops the active high side with a PWM compare level that an external PWM generator supplies. A current-limit comparator result also enters the block. When it trips, the high side stays off until the next PWM period begins.

All decisions are taken in one combinational stage and registered once, so every output follows its inputs one clock later. The requests rank as follows: stop first, then brake, then an invalid Hall code, then the all-off gap after a direction change, and normal commutation last. The output polarity of each side is a parameter, so the block can drive either N-type or P-type external switches. The length of the direction-change gap is also a parameter.

Top module: `hall_commutator`

## Requirements
- R1: In forward mode (dir_i = 0), with hall_i = {sensor3, sensor2, sensor1}, the codes map to the following (high side, low side) pairs: 3'b101 gives (V, U), 3'b001 gives (W, U), 3'b011 gives (W, V), 3'b010 gives (U, V), 3'b110 gives (U, W) and 3'b100 gives (V, W). In hi_o and lo_o, bit 0 is phase U, bit 1 is phase V and bit 2 is phase W.
- R2: In reverse mode (dir_i = 1), the block produces the pair that R1 gives for the bitwise complement of hall_i.
- R3: When hall_i is 3'b000 or 3'b111, all six enables are off.
- R4: During commutation the active low side stays on throughout. The active high side is on only in cycles in which pwm_cmp_i is high and no current limit is in force.
- R5: brake_i = 1 turns on all three high sides and turns off all three low sides, whatever hall_i, dir_i and pwm_cmp_i are.
- R6: While braking, ilim_i and any latched current limit have no effect on the outputs.
- R7: stop_i = 1 turns off all six enables and takes priority over brake_i.
- R8: A cycle with ilim_i = 1 turns off the high side. The high side stays off until the first cycle in which pwm_cmp_i rises from 0 to 1, which starts a new PWM period.
- R9: Any change of dir_i forces all six enables off for GAP_CYCLES cycles (default 1) before commutation resumes. A high side and a low side of the same phase are never on together.
- R10: The outputs are registered and follow the inputs with one clock of latency. While rst_n is low, all enables are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hall_i | input | 3 | Hall levels, bit 0 = sensor 1 |
| dir_i | input | 1 | 0 = forward, 1 = reverse |
| brake_i | input | 1 | 1 = short brake |
| stop_i | input | 1 | 1 = stop, 0 = run |
| pwm_cmp_i | input | 1 | PWM compare level, high = on-time |
| ilim_i | input | 1 | Current-limit comparator trip |
| hi_o | output | 3 | High-side enables, bit 0 = U, bit 1 = V, bit 2 = W |
| lo_o | output | 3 | Low-side enables, bit 0 = U, bit 1 = V, bit 2 = W |

## Verification
The bench builds the block with its default parameters: reverse on a high direction level, active-high outputs on both sides, and a one-cycle direction gap. With these values every enable can be compared bit for bit against the commutation table. The gap cycle that follows each random direction flip also appears in the output stream. Random PWM and current-limit patterns show the limit latch being set inside a period and cleared at the next rising compare edge. Random brake and stop overlaps show the priority order.

// File: rtl/hallc_pkg.sv
package hallc_pkg;

   localparam int NPH = 3;

   typedef struct packed {
      logic [NPH-1:0] hi;
      logic [NPH-1:0] lo;
   } drv_t;

   localparam drv_t DRV_OFF = '{hi: '0, lo: '0};

   // Forward commutation: code is {s3,s2,s1}; phase bits U=0,V=1,W=2
   function automatic drv_t fwd_map(input logic [NPH-1:0] code);
      drv_t d;
      d = DRV_OFF;
      unique case (code)
         3'b101: begin d.hi = 3'b010; d.lo = 3'b001; end
         3'b001: begin d.hi = 3'b100; d.lo = 3'b001; end
         3'b011: begin d.hi = 3'b100; d.lo = 3'b010; end
         3'b010: begin d.hi = 3'b001; d.lo = 3'b010; end
         3'b110: begin d.hi = 3'b001; d.lo = 3'b100; end
         3'b100: begin d.hi = 3'b010; d.lo = 3'b100; end
         default: d = DRV_OFF;
      endcase
      return d;
   endfunction

endpackage

// File: rtl/hallc_sense.sv
module hallc_sense
   import hallc_pkg::*;
#(
   parameter bit REV_WHEN_HIGH = 1'b1
) (
   input  logic [NPH-1:0] hall,
   input  logic           dir,
   output drv_t           comm,
   output logic           valid
);

   logic           rev;
   logic [NPH-1:0] code;

   generate
      if (REV_WHEN_HIGH) begin : g_rev_hi
         assign rev = dir;
      end else begin : g_rev_lo
         assign rev = ~dir;
      end
   endgenerate

   assign code  = hall ^ {NPH{rev}};
   assign valid = (hall != '0) && (hall != '1);
   assign comm  = fwd_map(code);

endmodule

// File: rtl/hallc_chop.sv
module hallc_chop (
   input  logic clk,
   input  logic rst_n,
   input  logic pwm_cmp,
   input  logic ilim,
   output logic gate
);

   logic prev_q;
   logic lat_q;
   logic period_start;
   logic lat_eff;

   assign period_start = pwm_cmp & ~prev_q;
   assign lat_eff      = lat_q & ~period_start;
   assign gate         = pwm_cmp & ~lat_eff & ~ilim;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         lat_q  <= 1'b0;
      end else begin
         prev_q <= pwm_cmp;
         lat_q  <= lat_eff | ilim;
      end
   end

endmodule

// File: rtl/hallc_dirgap.sv
module hallc_dirgap #(
   parameter int GAP_CYCLES = 1,
   localparam int CW = (GAP_CYCLES > 1) ? $clog2(GAP_CYCLES) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic dir,
   output logic blank
);

   logic          dir_q;
   logic [CW-1:0] cnt_q;
   logic          flip;

   assign flip  = dir ^ dir_q;
   assign blank = flip | (cnt_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q <= 1'b1;
         cnt_q <= '0;
      end else begin
         dir_q <= dir;
         if (flip)
            cnt_q <= CW'(GAP_CYCLES - 1);
         else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
      end
   end

endmodule

// File: rtl/hall_commutator.sv
module hall_commutator
   import hallc_pkg::*;
#(
   parameter bit REV_WHEN_HIGH = 1'b1,
   parameter bit HI_INV        = 1'b0,
   parameter bit LO_INV        = 1'b0,
   parameter int GAP_CYCLES    = 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [2:0]     hall_i,
   input  logic           dir_i,
   input  logic           brake_i,
   input  logic           stop_i,
   input  logic           pwm_cmp_i,
   input  logic           ilim_i,
   output logic [2:0]     hi_o,
   output logic [2:0]     lo_o
);

   if (GAP_CYCLES < 1) begin : g_bad_gap
      $error("GAP_CYCLES must be at least 1");
   end
   if (NPH != 3) begin : g_bad_nph
      $error("commutation table assumes three phases");
   end

   drv_t comm;
   logic valid;
   logic gate;
   logic blank;
   drv_t nxt;
   drv_t drv_q;

   hallc_sense #(.REV_WHEN_HIGH(REV_WHEN_HIGH)) u_sense (
      .hall  (hall_i),
      .dir   (dir_i),
      .comm  (comm),
      .valid (valid)
   );

   hallc_chop u_chop (
      .clk     (clk),
      .rst_n   (rst_n),
      .pwm_cmp (pwm_cmp_i),
      .ilim    (ilim_i),
      .gate    (gate)
   );

   hallc_dirgap #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
      .clk   (clk),
      .rst_n (rst_n),
      .dir   (dir_i),
      .blank (blank)
   );

   always_comb begin
      nxt = DRV_OFF;
      if (stop_i) begin
         nxt = DRV_OFF;
      end else if (brake_i) begin
         nxt.hi = '1;
         nxt.lo = '0;
      end else if (!valid || blank) begin
         nxt = DRV_OFF;
      end else begin
         nxt.hi = comm.hi & {NPH{gate}};
         nxt.lo = comm.lo;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) drv_q <= DRV_OFF;
      else        drv_q <= nxt;
   end

   generate
      if (HI_INV) begin : g_hi_n
         assign hi_o = ~drv_q.hi;
      end else begin : g_hi_p
         assign hi_o = drv_q.hi;
      end
      if (LO_INV) begin : g_lo_n
         assign lo_o = ~drv_q.lo;
      end else begin : g_lo_p
         assign lo_o = drv_q.lo;
      end
   endgenerate

endmodule

// File: rtl/hall_commutator_chk.sv
module hall_commutator_chk #(
   parameter bit HI_INV = 1'b0,
   parameter bit LO_INV = 1'b0
) (
   input logic       clk,
   input logic       rst_n,
   input logic [2:0] hall_i,
   input logic       dir_i,
   input logic       brake_i,
   input logic       stop_i,
   input logic       ilim_i,
   input logic [2:0] hi_o,
   input logic [2:0] lo_o
);

   localparam logic [2:0] HMASK = HI_INV ? 3'b111 : 3'b000;
   localparam logic [2:0] LMASK = LO_INV ? 3'b111 : 3'b000;

   logic [2:0] hi_raw;
   logic [2:0] lo_raw;
   logic       armed;

   assign hi_raw = hi_o ^ HMASK;
   assign lo_raw = lo_o ^ LMASK;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   // R9
   phase_shoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_raw & lo_raw) == 3'b000);

   // R7
   stop_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_i |=> (hi_raw == 3'b000 && lo_raw == 3'b000));

   // R5
   brake_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (brake_i && !stop_i) |=> (hi_raw == 3'b111 && lo_raw == 3'b000));

   // R3
   bad_hall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!stop_i && !brake_i && (hall_i == 3'b000 || hall_i == 3'b111))
      |=> (hi_raw == 3'b000 && lo_raw == 3'b000));

   // R8
   ilim_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ilim_i && !stop_i && !brake_i) |=> (hi_raw == 3'b000));

   // R9
   dir_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !stop_i && !brake_i && (dir_i != $past(dir_i)))
      |=> (hi_raw == 3'b000 && lo_raw == 3'b000));

   // R1
   lo_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lo_raw));

   // R4
   hi_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !brake_i |=> $onehot0(hi_raw));

endmodule

bind hall_commutator hall_commutator_chk #(.HI_INV(HI_INV), .LO_INV(LO_INV)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .hall_i  (hall_i),
   .dir_i   (dir_i),
   .brake_i (brake_i),
   .stop_i  (stop_i),
   .ilim_i  (ilim_i),
   .hi_o    (hi_o),
   .lo_o    (lo_o)
);

// File: tb/tb_hall_commutator.sv
module tb_hall_commutator;

   localparam int GAP = 1;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] hall_i = 3'b000;
   logic       dir_i = 1'b1;
   logic       brake_i = 1'b0;
   logic       stop_i = 1'b1;
   logic       pwm_cmp_i = 1'b0;
   logic       ilim_i = 1'b0;
   logic [2:0] hi_o;
   logic [2:0] lo_o;

   int total = 0;
   int bad = 0;
   bit done = 0;

   // model state
   bit m_dir_q = 1'b1;
   int m_gap = 0;
   bit m_prev = 1'b0;
   bit m_lat = 1'b0;
   logic [2:0] e_hi, e_lo;

   always #10 clk = ~clk;

   hall_commutator #(.GAP_CYCLES(GAP)) dut (
      .clk(clk), .rst_n(rst_n), .hall_i(hall_i), .dir_i(dir_i),
      .brake_i(brake_i), .stop_i(stop_i), .pwm_cmp_i(pwm_cmp_i),
      .ilim_i(ilim_i), .hi_o(hi_o), .lo_o(lo_o));

   // R1 pairs: returns {high phase, low phase} one-hot, forward order
   function automatic logic [5:0] pair_of(input logic [2:0] c);
      case (c)
         3'b001: pair_of = {3'b100, 3'b001};
         3'b010: pair_of = {3'b001, 3'b010};
         3'b011: pair_of = {3'b100, 3'b010};
         3'b100: pair_of = {3'b010, 3'b100};
         3'b101: pair_of = {3'b010, 3'b001};
         3'b110: pair_of = {3'b001, 3'b100};
         default: pair_of = 6'b0;
      endcase
   endfunction

   task automatic check(input string tag);
      total++;
      if (hi_o !== e_hi || lo_o !== e_lo) begin
         bad++;
         $display("FAIL %s: hi=%b lo=%b expected hi=%b lo=%b", tag, hi_o, lo_o, e_hi, e_lo);
      end
   endtask

   // called at a negedge: apply inputs, predict, wait one cycle, compare
   task automatic step(input logic [2:0] h, input bit d, input bit b, input bit s,
                       input bit p, input bit il, input string tag_in);
      bit rise, eff, gate, flip, blank;
      logic [5:0] pr;
      string tag;
      hall_i = h; dir_i = d; brake_i = b; stop_i = s; pwm_cmp_i = p; ilim_i = il;
      rise  = p && !m_prev;
      eff   = m_lat && !rise;
      gate  = p && !eff && !il;
      flip  = (d != m_dir_q);
      blank = flip || (m_gap != 0);
      pr    = pair_of(d ? ~h : h);
      tag   = tag_in;
      if (s) begin
         e_hi = 3'b000; e_lo = 3'b000; if (tag == "") tag = "R7";
      end else if (b) begin
         e_hi = 3'b111; e_lo = 3'b000; if (tag == "") tag = il ? "R6" : "R5";
      end else if (h == 3'b000 || h == 3'b111) begin
         e_hi = 3'b000; e_lo = 3'b000; if (tag == "") tag = "R3";
      end else if (blank) begin
         e_hi = 3'b000; e_lo = 3'b000; if (tag == "") tag = "R9";
      end else begin
         e_hi = gate ? pr[5:3] : 3'b000;
         e_lo = pr[2:0];
         if (tag == "") tag = !gate ? ((il || eff) ? "R8" : "R4") : (d ? "R2" : "R1");
      end
      if (flip) m_gap = GAP - 1; else if (m_gap > 0) m_gap--;
      m_dir_q = d;
      m_prev  = p;
      m_lat   = eff || il;
      @(negedge clk);
      check(tag);
   endtask

   initial begin
      void'($urandom(32'd5150));
      repeat (3) @(negedge clk);
      e_hi = 3'b000; e_lo = 3'b000;
      check("R10");                          // reset state
      rst_n = 1'b1;
      // settle direction forward (R9 gap), then walk forward codes
      step(3'b101, 0, 0, 0, 1, 0, "R9");
      begin
         logic [2:0] fwd [6] = '{3'b101, 3'b001, 3'b011, 3'b010, 3'b110, 3'b100};
         foreach (fwd[k]) step(fwd[k], 0, 0, 0, 1, 0, "R1");
         step(3'b011, 0, 0, 0, 0, 0, "R4");  // PWM off: low side stays
         step(3'b011, 0, 0, 0, 1, 0, "R4");
         step(3'b011, 1, 0, 0, 1, 0, "R9");  // direction flip gap
         foreach (fwd[k]) step(~fwd[k], 1, 0, 0, 1, 0, "R2");
      end
      step(3'b000, 1, 0, 0, 1, 0, "R3");
      step(3'b111, 1, 0, 0, 1, 0, "R3");
      step(3'b010, 1, 1, 0, 0, 1, "R6");     // brake with limit and PWM low
      step(3'b000, 1, 1, 0, 1, 0, "R5");     // brake ignores invalid Hall
      step(3'b010, 1, 1, 1, 1, 0, "R7");     // stop beats brake
      // current limit latch across a PWM period
      step(3'b101, 1, 0, 0, 1, 0, "R2");
      step(3'b101, 1, 0, 0, 1, 1, "R8");
      step(3'b101, 1, 0, 0, 1, 0, "R8");     // latched, still off
      step(3'b101, 1, 0, 0, 0, 0, "R8");
      step(3'b101, 1, 0, 0, 1, 0, "R8");     // new period: high side back
      // random phase
      for (int n = 0; n < 4000; n++) begin
         logic [2:0] h;
         bit d, b, s, p, il;
         h  = 3'($urandom_range(0, 7));
         d  = ($urandom_range(0, 19) == 0) ? !dir_i : dir_i;
         b  = ($urandom_range(0, 9) == 0);
         s  = ($urandom_range(0, 14) == 0);
         p  = ($urandom_range(0, 3) != 0) ? pwm_cmp_i : !pwm_cmp_i;
         il = ($urandom_range(0, 11) == 0);
         step(h, d, b, s, p, il, "");
      end
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(20 * 100000);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog R10: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule